// File: doc/BRIEF.md
# Translation Buffer with Protection Checking

This block caches virtual-to-physical page mappings and vets every access against them. A lookup presents a 32-bit virtual address, an access kind (read, write or execute) and an instruction address whose two low bits carry the current privilege level. The upper 20 bits of the virtual address select the page; the buffer is fully associative and holds sixteen mappings. One clock later it returns a valid strobe together with hit or miss, the physical page number, the page-size code, the assembled physical address and a protection-fault flag.

A hit is not enough for an access to go ahead. Two checks must both pass. The first is an identity check: the entry's 15-bit access ID must equal one of eight protection IDs, and a write also needs a matching ID whose write-disable bit is clear. The second is a rights check: the entry's rights type must allow the access kind, and the current privilege level must be at or above the level the entry requires. If either check fails on a hit, a protection fault is raised.

Software fills the buffer through an insert port and removes mappings through a purge port. Four 64-bit registers hold the eight protection IDs and can be written. Page-table walks on a miss are handled outside this block.

Top module: `tlb_prot_top`

## Requirements
- R1: A lookup request in one cycle gives `rsp_valid` high in the next cycle with its result; without a request `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are low in the next cycle.
- R2: The page number is `lk_vaddr[31:12]`. A lookup hits when a valid entry holds that page number, and then returns its physical page number on `rsp_ppn`. Otherwise it reports a miss, and a miss never carries a fault.
- R3: Page-size code k (0 to 7) means a page of 4 KB times 4^k. `rsp_paddr` takes its low 12+2k bits from `lk_vaddr`. Its remaining bits come from `{ppn, 12'b0}`, and `rsp_psize` returns k.
- R4: Protection register s (0 to 3) holds ID 2s in data bits [31:0] and ID 2s+1 in bits [63:32]. All IDs reset to zero. A write is seen by lookups from the next cycle on; a lookup in the same cycle still sees the old IDs.
- R5: The identity check passes for a read or execute when at least one protection ID has bits [15:1] equal to the entry's access ID. Bits [31:16] are ignored.
- R6: Bit 0 of a protection ID disables writes. A write passes the identity check only if some matching ID has bit 0 clear.
- R7: Rights type 0 allows read only, 1 allows read and write, 2 allows execute only, and 3 allows read and execute. Access kind 0 is read, 1 is write and 2 is execute. Kind 3 is never permitted.
- R8: The current level is `lk_iaddr[1:0]`, where 0 is the most privileged. The level check passes when the current level is numerically less than or equal to the entry's required level.
- R9: `rsp_fault` is high exactly when the lookup hits and the identity check or the rights and level check fails.
- R10: An insert whose page number matches a valid entry overwrites that entry in place. Any other insert writes to a round-robin slot that starts at 0 after reset and advances by one, wrapping from 15 to 0, only on such inserts.
- R11: A purge invalidates any valid entry with the purge page number. A purge and an insert of the same page in one cycle leave that page invalid. A lookup in the cycle of an insert or purge sees the table as it was before that cycle.
- R12: After reset all entries are invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_iaddr | input | 32 | Instruction address; bits [1:0] give the current privilege level |
| ins_en | input | 1 | Insert a mapping |
| ins_vpn | input | 20 | Page number to insert |
| ins_ppn | input | 20 | Physical page number to insert |
| ins_rtype | input | 2 | Rights type of the new entry |
| ins_rpl | input | 2 | Required privilege level of the new entry |
| ins_aid | input | 15 | Access ID of the new entry |
| ins_psize | input | 3 | Page-size code of the new entry |
| pur_en | input | 1 | Purge by page number |
| pur_vpn | input | 20 | Page number to purge |
| pid_we | input | 1 | Write a protection register |
| pid_sel | input | 2 | Protection register index |
| pid_wdata | input | 64 | Two protection IDs to store |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_fault | output | 1 | Protection fault |
| rsp_ppn | output | 20 | Physical page number of the hit |
| rsp_psize | output | 3 | Page-size code of the hit |
| rsp_paddr | output | 32 | Physical address |

## Verification
A bad valid bit or a stale page number shows at the ports on the next lookup of that page, as a wrong hit or miss one cycle after the request. A replacement pointer that has slipped stays hidden until an eviction removes the wrong mapping. That shows later as an unexpected miss on a page that should still be present, or an unexpected hit on one that should have been evicted. A corrupted protection ID or rights field shows only on `rsp_fault`, and only for the access kinds and levels that reach the corrupted bit. The bench therefore compares every output against a behavioural model on every clock, and it sweeps kinds, levels and write-disable combinations for each entry.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RT_RO = 2'd0,
    RT_RW = 2'd1,
    RT_EX = 2'd2,
    RT_RX = 2'd3
  } rights_e;

  // Rights-type permission for an access kind, then the privilege comparison.
  function automatic logic rights_pass(input logic [1:0] kind,
                                       input logic [1:0] rtype,
                                       input logic [1:0] req_pl,
                                       input logic [1:0] cur_pl);
    logic type_ok;
    case (acc_kind_e'(kind))
      ACC_RD:  type_ok = (rights_e'(rtype) != RT_EX);
      ACC_WR:  type_ok = (rights_e'(rtype) == RT_RW);
      ACC_EX:  type_ok = (rights_e'(rtype) == RT_EX) || (rights_e'(rtype) == RT_RX);
      default: type_ok = 1'b0;
    endcase
    return type_ok && (cur_pl <= req_pl);
  endfunction

endpackage

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
  parameter int N_ENT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  output logic [$clog2(N_ENT)-1:0]   slot
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign slot = ptr_q;

  // R10
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(slot));

  // R10
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && slot != LAST) |=> (slot == $past(slot) + 1'b1));

endmodule

// File: rtl/tlb_pid_bank.sv
module tlb_pid_bank #(
  parameter int N_PID = 8,
  parameter int PID_W = 32,
  parameter int AID_W = 15
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [$clog2(N_PID/2)-1:0]         sel,
  input  logic [2*PID_W-1:0]                 wdata,
  input  logic [AID_W-1:0]                   chk_aid,
  input  logic                               chk_write,
  output logic                               id_ok
);
  localparam int N_PREG = N_PID / 2;

  logic [N_PREG-1:0][2*PID_W-1:0] preg_q, preg_d;
  logic [N_PID-1:0] id_match, id_wr_ok;

  always_comb begin
    preg_d = preg_q;
    if (we) preg_d[sel] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preg_q <= '0;
    else        preg_q <= preg_d;
  end

  for (genvar j = 0; j < N_PID; j++) begin : g_id
    logic [PID_W-1:0] pid;
    assign pid         = preg_q[j/2][(j%2)*PID_W +: PID_W];
    assign id_match[j] = (pid[AID_W:1] == chk_aid);
    assign id_wr_ok[j] = id_match[j] && !pid[0];
  end

  assign id_ok = chk_write ? (|id_wr_ok) : (|id_match);

  // R4
  pid_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (preg_q[$past(sel)] == $past(wdata)));

  // R6
  wr_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_write && id_ok) |-> (|id_match));

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N_ENT = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int AID_W = 15,
  parameter int PSZ_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VPN_W-1:0]           lk_vpn,
  output logic                       lk_hit,
  output logic [PPN_W-1:0]           lk_ppn,
  output logic [1:0]                 lk_rtype,
  output logic [1:0]                 lk_rpl,
  output logic [AID_W-1:0]           lk_aid,
  output logic [PSZ_W-1:0]           lk_psize,
  input  logic                       ins_en,
  input  logic [VPN_W-1:0]           ins_vpn,
  input  logic [PPN_W-1:0]           ins_ppn,
  input  logic [1:0]                 ins_rtype,
  input  logic [1:0]                 ins_rpl,
  input  logic [AID_W-1:0]           ins_aid,
  input  logic [PSZ_W-1:0]           ins_psize,
  input  logic [$clog2(N_ENT)-1:0]   ins_slot,
  output logic                       ins_found,
  input  logic                       pur_en,
  input  logic [VPN_W-1:0]           pur_vpn
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] v_q, v_d, lk_m, ins_m, pur_m, wr_en;
  logic [VPN_W-1:0] vpn_q   [N_ENT];
  logic [PPN_W-1:0] ppn_q   [N_ENT];
  logic [1:0]       rtype_q [N_ENT];
  logic [1:0]       rpl_q   [N_ENT];
  logic [AID_W-1:0] aid_q   [N_ENT];
  logic [PSZ_W-1:0] psz_q   [N_ENT];
  logic             same_page_kill;

  assign same_page_kill = pur_en && (pur_vpn == ins_vpn);
  assign ins_found      = |ins_m;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign lk_m[g]  = v_q[g] && (vpn_q[g] == lk_vpn);
    assign ins_m[g] = v_q[g] && (vpn_q[g] == ins_vpn);
    assign pur_m[g] = v_q[g] && (vpn_q[g] == pur_vpn);
    assign wr_en[g] = ins_en && (ins_found ? ins_m[g] : (ins_slot == IDX_W'(g)));

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        vpn_q[g]   <= ins_vpn;
        ppn_q[g]   <= ins_ppn;
        rtype_q[g] <= ins_rtype;
        rpl_q[g]   <= ins_rpl;
        aid_q[g]   <= ins_aid;
        psz_q[g]   <= ins_psize;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      if (wr_en[i])                  v_d[i] = !same_page_kill;
      else if (pur_en && pur_m[i])   v_d[i] = 1'b0;
      else                           v_d[i] = v_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_comb begin
    lk_ppn   = '0;
    lk_rtype = '0;
    lk_rpl   = '0;
    lk_aid   = '0;
    lk_psize = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (lk_m[i]) begin
        lk_ppn   = lk_ppn   | ppn_q[i];
        lk_rtype = lk_rtype | rtype_q[i];
        lk_rpl   = lk_rpl   | rpl_q[i];
        lk_aid   = lk_aid   | aid_q[i];
        lk_psize = lk_psize | psz_q[i];
      end
    end
  end

  assign lk_hit = |lk_m;

  // R10
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m));

  // R11
  purge_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pur_en && !ins_en) |=> ((lk_vpn != $past(pur_vpn)) || !lk_hit));

endmodule

// File: rtl/tlb_prot_top.sv
module tlb_prot_top #(
  parameter int VA_W  = 32,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int AID_W = 15,
  parameter int PSZ_W = 3,
  parameter int N_ENT = 16,
  parameter int N_PID = 8,
  parameter int PID_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_req,
  input  logic [VA_W-1:0]               lk_vaddr,
  input  logic [1:0]                    lk_kind,
  input  logic [VA_W-1:0]               lk_iaddr,
  input  logic                          ins_en,
  input  logic [VPN_W-1:0]              ins_vpn,
  input  logic [PPN_W-1:0]              ins_ppn,
  input  logic [1:0]                    ins_rtype,
  input  logic [1:0]                    ins_rpl,
  input  logic [AID_W-1:0]              ins_aid,
  input  logic [PSZ_W-1:0]              ins_psize,
  input  logic                          pur_en,
  input  logic [VPN_W-1:0]              pur_vpn,
  input  logic                          pid_we,
  input  logic [$clog2(N_PID/2)-1:0]    pid_sel,
  input  logic [2*PID_W-1:0]            pid_wdata,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_miss,
  output logic                          rsp_fault,
  output logic [PPN_W-1:0]              rsp_ppn,
  output logic [PSZ_W-1:0]              rsp_psize,
  output logic [PPN_W+VA_W-VPN_W-1:0]   rsp_paddr
);
  import tlbp_pkg::*;

  localparam int OFF_W = VA_W - VPN_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = $clog2(N_ENT);

  logic [VPN_W-1:0] lk_vpn;
  logic             e_hit, ins_found, id_ok, rt_ok;
  logic [PPN_W-1:0] e_ppn;
  logic [1:0]       e_rtype, e_rpl;
  logic [AID_W-1:0] e_aid;
  logic [PSZ_W-1:0] e_psize;
  logic [IDX_W-1:0] rr_slot;
  logic [PA_W-1:0]  pa_base, pa_c;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  tlb_entry_array #(
    .N_ENT(N_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .AID_W(AID_W), .PSZ_W(PSZ_W)
  ) u_ents (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_hit(e_hit), .lk_ppn(e_ppn), .lk_rtype(e_rtype),
    .lk_rpl(e_rpl), .lk_aid(e_aid), .lk_psize(e_psize),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_rtype(ins_rtype),
    .ins_rpl(ins_rpl), .ins_aid(ins_aid), .ins_psize(ins_psize),
    .ins_slot(rr_slot), .ins_found(ins_found),
    .pur_en(pur_en), .pur_vpn(pur_vpn)
  );

  tlb_repl_ptr #(.N_ENT(N_ENT)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(ins_en && !ins_found), .slot(rr_slot)
  );

  tlb_pid_bank #(.N_PID(N_PID), .PID_W(PID_W), .AID_W(AID_W)) u_pids (
    .clk(clk), .rst_n(rst_n), .we(pid_we), .sel(pid_sel), .wdata(pid_wdata),
    .chk_aid(e_aid), .chk_write(lk_kind == 2'(ACC_WR)), .id_ok(id_ok)
  );

  assign rt_ok   = rights_pass(lk_kind, e_rtype, e_rpl, lk_iaddr[1:0]);
  assign pa_base = {e_ppn, {OFF_W{1'b0}}};

  always_comb begin
    int offb;
    offb = OFF_W + 2 * int'(e_psize);
    for (int i = 0; i < PA_W; i++) begin
      if (i < offb && i < VA_W) pa_c[i] = lk_vaddr[i];
      else                      pa_c[i] = pa_base[i];
    end
  end

  logic             vld_q, hit_q, miss_q, flt_q;
  logic             vld_d, hit_d, miss_d, flt_d;
  logic [PPN_W-1:0] ppn_q, ppn_d;
  logic [PSZ_W-1:0] psz_q, psz_d;
  logic [PA_W-1:0]  pa_q, pa_d;

  always_comb begin
    vld_d  = lk_req;
    hit_d  = lk_req && e_hit;
    miss_d = lk_req && !e_hit;
    flt_d  = lk_req && e_hit && !(id_ok && rt_ok);
    ppn_d  = ppn_q;
    psz_d  = psz_q;
    pa_d   = pa_q;
    if (lk_req) begin
      ppn_d = e_ppn;
      psz_d = e_psize;
      pa_d  = pa_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      flt_q  <= 1'b0;
      ppn_q  <= '0;
      psz_q  <= '0;
      pa_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
      flt_q  <= flt_d;
      ppn_q  <= ppn_d;
      psz_q  <= psz_d;
      pa_q   <= pa_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_miss  = miss_q;
  assign rsp_fault = flt_q;
  assign rsp_ppn   = ppn_q;
  assign rsp_psize = psz_q;
  assign rsp_paddr = pa_q;

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault));

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));

  // R9
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_valid));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

endmodule

// File: tb/tb_tlb_prot_top.sv
module tb_tlb_prot_top;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic [31:0] lk_iaddr;
  logic        ins_en;
  logic [19:0] ins_vpn;
  logic [19:0] ins_ppn;
  logic [1:0]  ins_rtype;
  logic [1:0]  ins_rpl;
  logic [14:0] ins_aid;
  logic [2:0]  ins_psize;
  logic        pur_en;
  logic [19:0] pur_vpn;
  logic        pid_we;
  logic [1:0]  pid_sel;
  logic [63:0] pid_wdata;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [19:0] rsp_ppn;
  logic [2:0]  rsp_psize;
  logic [31:0] rsp_paddr;

  tlb_prot_top dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_iaddr(lk_iaddr), .ins_en(ins_en), .ins_vpn(ins_vpn),
    .ins_ppn(ins_ppn), .ins_rtype(ins_rtype), .ins_rpl(ins_rpl), .ins_aid(ins_aid),
    .ins_psize(ins_psize), .pur_en(pur_en), .pur_vpn(pur_vpn), .pid_we(pid_we),
    .pid_sel(pid_sel), .pid_wdata(pid_wdata), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_ppn(rsp_ppn), .rsp_psize(rsp_psize), .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit running = 1'b0;

  // Behavioural reference state
  bit          m_v    [16];
  logic [19:0] m_vpn  [16];
  logic [19:0] m_ppn  [16];
  logic [1:0]  m_rt   [16];
  logic [1:0]  m_rpl  [16];
  logic [14:0] m_aid  [16];
  logic [2:0]  m_psz  [16];
  logic [31:0] m_pid  [8];
  int          m_rr;

  bit          x_valid, x_hit, x_miss, x_fault;
  logic [19:0] x_ppn;
  logic [2:0]  x_psz;
  logic [31:0] x_pa;
  string       x_why;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
      for (int j = 0; j < 8; j++) m_pid[j] = 32'h0;
      m_rr = 0;
      x_valid = 0; x_hit = 0; x_miss = 0; x_fault = 0;
    end else begin
      int idx, found, slot;
      bit anym, anyw, idok, tok, lvok;
      logic [31:0] base;
      x_valid = lk_req; x_hit = 0; x_miss = 0; x_fault = 0; x_why = "R9";
      if (lk_req) begin
        idx = -1;
        for (int i = 0; i < 16; i++)
          if (m_v[i] && m_vpn[i] == lk_vaddr[31:12]) idx = i;
        if (idx < 0) x_miss = 1;
        else begin
          x_hit = 1;
          x_ppn = m_ppn[idx];
          x_psz = m_psz[idx];
          anym = 0; anyw = 0;
          for (int j = 0; j < 8; j++)
            if (m_pid[j][15:1] == m_aid[idx]) begin
              anym = 1;
              if (!m_pid[j][0]) anyw = 1;
            end
          idok = (lk_kind == 2'd1) ? anyw : anym;
          case (lk_kind)
            2'd0: tok = (m_rt[idx] != 2'd2);
            2'd1: tok = (m_rt[idx] == 2'd1);
            2'd2: tok = (m_rt[idx] == 2'd2) || (m_rt[idx] == 2'd3);
            default: tok = 0;
          endcase
          lvok = (lk_iaddr[1:0] <= m_rpl[idx]);
          x_fault = !(idok && tok && lvok);
          if (!anym) x_why = "R4 R5 R9";
          else if (!idok) x_why = "R6 R9";
          else if (!tok) x_why = "R7 R9";
          else if (!lvok) x_why = "R8 R9";
          base = {m_ppn[idx], 12'h000};
          for (int b = 0; b < 32; b++)
            x_pa[b] = (b < 12 + 2 * int'(m_psz[idx])) ? lk_vaddr[b] : base[b];
        end
      end
      if (pid_we) begin
        m_pid[2 * pid_sel]     = pid_wdata[31:0];
        m_pid[2 * pid_sel + 1] = pid_wdata[63:32];
      end
      found = -1;
      if (ins_en)
        for (int i = 0; i < 16; i++)
          if (m_v[i] && m_vpn[i] == ins_vpn) found = i;
      if (pur_en)
        for (int i = 0; i < 16; i++)
          if (m_v[i] && m_vpn[i] == pur_vpn) m_v[i] = 0;
      if (ins_en) begin
        slot = (found >= 0) ? found : m_rr;
        m_vpn[slot] = ins_vpn; m_ppn[slot] = ins_ppn; m_rt[slot] = ins_rtype;
        m_rpl[slot] = ins_rpl; m_aid[slot] = ins_aid; m_psz[slot] = ins_psize;
        m_v[slot] = !(pur_en && pur_vpn == ins_vpn);
        if (found < 0) m_rr = (m_rr + 1) % 16;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      chk(rsp_valid == x_valid, "R1", "valid", 32'(rsp_valid), 32'(x_valid));
      if (x_valid) begin
        chk(rsp_hit == x_hit, "R2 R10 R11", "hit", 32'(rsp_hit), 32'(x_hit));
        chk(rsp_miss == x_miss, "R2", "miss", 32'(rsp_miss), 32'(x_miss));
        chk(rsp_fault == x_fault, x_why, "fault", 32'(rsp_fault), 32'(x_fault));
        if (x_hit) begin
          chk(rsp_ppn == x_ppn, "R2", "ppn", 32'(rsp_ppn), 32'(x_ppn));
          chk(rsp_psize == x_psz, "R3", "psize", 32'(rsp_psize), 32'(x_psz));
          chk(rsp_paddr == x_pa, "R3", "paddr", rsp_paddr, x_pa);
        end
      end else begin
        chk(!(rsp_hit || rsp_miss || rsp_fault), "R1", "idle flags",
            {29'd0, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
      end
    end
  end

  task automatic clr();
    lk_req = 0; ins_en = 0; pur_en = 0; pid_we = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic set_lk(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] pl);
    lk_req = 1; lk_vaddr = va; lk_kind = kind; lk_iaddr = {30'h1000, pl};
  endtask

  task automatic set_ins(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] rt,
                         input logic [1:0] rpl, input logic [14:0] aid, input logic [2:0] psz);
    ins_en = 1; ins_vpn = vpn; ins_ppn = ppn; ins_rtype = rt; ins_rpl = rpl;
    ins_aid = aid; ins_psize = psz;
  endtask

  task automatic set_pid(input logic [1:0] s, input logic [31:0] hi, input logic [31:0] lo);
    pid_we = 1; pid_sel = s; pid_wdata = {hi, lo};
  endtask

  task automatic sweep(input logic [19:0] vpn);
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++) begin
        set_lk({vpn, 12'hA5C}, 2'(k), 2'(p));
        tick();
      end
  endtask

  initial begin
    rst_n = 0;
    clr();
    lk_vaddr = 0; lk_kind = 0; lk_iaddr = 0; ins_vpn = 0; ins_ppn = 0;
    ins_rtype = 0; ins_rpl = 0; ins_aid = 0; ins_psize = 0; pur_vpn = 0;
    pid_sel = 0; pid_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: outputs idle after reset
    chk(rsp_valid == 0, "R12", "valid after reset", 32'(rsp_valid), 32'd0);
    running = 1;
    // R12: empty table misses
    set_lk(32'h0000_0123, 2'd0, 2'd0); tick();
    set_lk(32'h0001_0123, 2'd0, 2'd0); tick();
    tick();
    // R4: protection IDs, low and high halves
    set_pid(2'd0, {16'h0, 15'd5, 1'b1}, {16'h0, 15'd5, 1'b0}); tick();
    set_pid(2'd1, {16'h1234, 15'd9, 1'b0}, {16'h0, 15'd7, 1'b1}); tick();
    set_pid(2'd3, {16'h0, 15'h3FF, 1'b0}, {16'hFFFF, 15'd5, 1'b1}); tick();
    set_pid(2'd2, {16'h0, 15'd11, 1'b1}, {16'h0, 15'd11, 1'b1}); tick();
    // Entries with varied rights, levels, IDs and sizes (R5 R6 R7 R8 R3)
    set_ins(20'h00010, 20'hABCDE, 2'd1, 2'd3, 15'd5,     3'd0); tick();
    set_ins(20'h00020, 20'h12345, 2'd0, 2'd3, 15'd7,     3'd1); tick();
    set_ins(20'h00030, 20'h0F0F0, 2'd2, 2'd0, 15'd5,     3'd2); tick();
    set_ins(20'h00040, 20'hFFFFF, 2'd3, 2'd1, 15'h3FF,   3'd7); tick();
    set_ins(20'h00050, 20'h55555, 2'd1, 2'd3, 15'h55,    3'd4); tick();
    set_ins(20'h00060, 20'h6789A, 2'd1, 2'd2, 15'd9,     3'd3); tick();
    set_ins(20'h00070, 20'h7777F, 2'd1, 2'd3, 15'd11,    3'd5); tick();
    set_ins(20'h00080, 20'h80808, 2'd3, 2'd3, 15'd0,     3'd6); tick();
    for (int e = 1; e <= 8; e++) sweep(20'(e * 16));
    // R4: same-cycle ID write is not seen; next cycle it is
    set_pid(2'd2, {16'h0, 15'd11, 1'b0}, {16'h0, 15'd11, 1'b1});
    set_lk({20'h00070, 12'h004}, 2'd1, 2'd0); tick();
    set_lk({20'h00070, 12'h004}, 2'd1, 2'd0); tick();
    // R10: overwrite in place
    set_ins(20'h00010, 20'h11111, 2'd0, 2'd0, 15'd5, 3'd2); tick();
    sweep(20'h00010);
    // R11: lookup sees old table during insert and purge
    set_ins(20'h00090, 20'h99999, 2'd1, 2'd3, 15'd5, 3'd0);
    set_lk({20'h00090, 12'h010}, 2'd0, 2'd0); tick();
    set_lk({20'h00090, 12'h010}, 2'd0, 2'd0); tick();
    pur_en = 1; pur_vpn = 20'h00090;
    set_lk({20'h00090, 12'h010}, 2'd0, 2'd0); tick();
    set_lk({20'h00090, 12'h010}, 2'd0, 2'd0); tick();
    // R11: purge and insert of the same page together
    pur_en = 1; pur_vpn = 20'h000A0;
    set_ins(20'h000A0, 20'hAAAAA, 2'd1, 2'd3, 15'd5, 3'd0); tick();
    set_lk({20'h000A0, 12'h010}, 2'd0, 2'd0); tick();
    // R10: fill past capacity, round-robin eviction
    for (int n = 0; n < 20; n++) begin
      set_ins(20'h00100 + 20'(n), 20'h20000 + 20'(n), 2'd1, 2'd3, 15'd5, 3'(n % 8)); tick();
    end
    for (int n = 0; n < 20; n++) begin
      set_lk({20'h00100 + 20'(n), 12'h3C4}, 2'd1, 2'd3); tick();
    end
    // Mixed pseudo-random traffic over a small page range
    for (int c = 0; c < 6000; c++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) set_lk({20'($urandom_range(0, 40)), 12'($urandom)}, 2'($urandom), 2'($urandom));
      if (op == 5 || op == 9)
        set_ins(20'($urandom_range(0, 40)), 20'($urandom), 2'($urandom), 2'($urandom),
                15'($urandom_range(0, 12)), 3'($urandom));
      if (op == 6) begin pur_en = 1; pur_vpn = 20'($urandom_range(0, 40)); end
      if (op == 7)
        set_pid(2'($urandom), {16'($urandom), 15'($urandom_range(0, 12)), 1'($urandom)},
                {16'($urandom), 15'($urandom_range(0, 12)), 1'($urandom)});
      if (op == 9) set_lk({20'($urandom_range(0, 40)), 12'($urandom)}, 2'($urandom), 2'($urandom));
      tick();
    end
    tick();
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule